// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block collects up to 128 interrupt sources and presents them to one processor interrupt request line. Software reaches each source indirectly. It first writes a source number into a select register. Reads and writes to the mode, vector, mask and command registers then act on that one source. Each source has a 3-bit priority, a trigger type (level-high or rising-edge), a 32-bit vector and an enable bit.

The block picks one winner from the sources that are enabled, pending and above the current in-service level. It raises the request line while a winner exists. The interrupt service routine reads the vector register to acknowledge the interrupt. That read returns the winner's vector and pushes the winner's priority onto an 8-level in-service stack, so only strictly higher priorities can preempt it. A write to the end-of-interrupt register pops one level. When nothing qualifies, the vector read returns a programmable spurious value. The register port is 32 bits wide with separate read and write strobes. Reads are combinational. Writes and read side effects take effect at the clock edge.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the request line is low, the vector read returns 0 (the spurious register resets to 0), the status register reads 0, and all pending words read 0.
- R2: A write to offset 0x00 selects the source given by wdata[6:0]. Offset 0x04 (priority in bits [2:0], edge trigger flag in bit 5) and offset 0x08 (vector) read and write the selected source only. If the selected number is NSRC or higher, writes have no effect and reads return 0.
- R3: A write to 0x40 sets the enable bit of the selected source, and a write to 0x44 clears it. No other source's enable changes. Offset 0x30 returns the selected source's enable bit in bit 0.
- R4: A write to 0x4C makes the selected source pending, and a write to 0x48 removes its latched pending state. Offsets 0x20, 0x24, 0x28 and 0x2C each show the pending state of 32 sources, with bit b of word k belonging to source 32k+b.
- R5: A level source (bit 5 = 0) is pending whenever its input is high or its latch is set. An edge source (bit 5 = 1) latches pending on a 0-to-1 input transition and stays pending after the input falls.
- R6: One cycle after some enabled, pending source has a priority strictly above the top of the in-service stack, the request output is high; with an empty stack any priority qualifies. Disabled sources never raise it.
- R7: Among the qualifying sources, the highest priority wins (7 is highest). On a tie, the lowest source number wins. A read of 0x10 returns the winner's vector.
- R8: A read of 0x10 with no qualifying source returns the spurious register (offset 0x3C) and leaves the stack unchanged.
- R9: A read of 0x10 with a winner pushes its priority and number. Offset 0x18 then returns that number, and only strictly higher priorities can raise the request line until it is popped.
- R10: The acknowledging read clears the pending latch of an edge winner. A level winner stays pending while its input or latch holds.
- R11: A write to 0x38 pops one stack level and does nothing on an empty stack. Eight writes always empty the stack, after which 0x18 reads 0.
- R12: Offset 0x34 returns the request output in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on the vector register) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| src_irq | input | NSRC | Interrupt source inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NSRC = 40. This leaves the second pending word only partly populated and the upper two words empty. It also makes source numbers 40 to 127 selectable but absent, so out-of-range selects are exercised. Directed sequences cover equal-priority ties, refused same-level preemption, a full eight-write unwind, and edge against level acknowledge. Random register traffic from a fixed seed then drives a bench model of priorities, latches and the stack through many nested states.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC  = 128,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [NSRC-1:0] src_irq,
  output logic            irq_out
);
  localparam int SW = 7;
  localparam int PW = 3;
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08, A_IVR = 8'h10,
                         A_ISR = 8'h18, A_PW0 = 8'h20, A_PW1 = 8'h24, A_PW2 = 8'h28,
                         A_PW3 = 8'h2C, A_MSK = 8'h30, A_CST = 8'h34, A_EOI = 8'h38,
                         A_SPU = 8'h3C, A_EN = 8'h40, A_DIS = 8'h44, A_CLR = 8'h48,
                         A_SET = 8'h4C;

  logic [SW-1:0]   sel, sidx;
  logic            sel_ok;
  logic [PW-1:0]   prio_m [NSRC];
  logic [31:0]     vec_m  [NSRC];
  logic [NSRC-1:0] en, edge_m, pend_l, pend_nxt, src_prev, pend_eff;
  logic [31:0]     spu;
  logic [PW-1:0]   stk_p  [DEPTH];
  logic [SW-1:0]   stk_id [DEPTH];
  logic [DW-1:0]   depth;
  logic [PW-1:0]   top_p;
  logic [SW-1:0]   cur_id;
  logic            win_ok, ack, eoi, irq_q;
  logic [SW-1:0]   win_id;
  logic [PW-1:0]   win_p;
  logic [127:0]    pend_pad;

  assign sel_ok   = int'(sel) < NSRC;
  assign sidx     = sel_ok ? sel : '0;
  assign pend_eff = pend_l | (src_irq & ~edge_m);
  assign pend_pad = 128'(pend_eff);
  assign top_p    = (depth != 0) ? stk_p[IW'(depth - DW'(1))] : '0;
  assign cur_id   = (depth != 0) ? stk_id[IW'(depth - DW'(1))] : '0;
  assign ack      = rd_en && addr == A_IVR && win_ok;
  assign eoi      = wr_en && addr == A_EOI && depth != 0;
  assign irq_out  = irq_q;

  always_comb begin
    win_ok = 1'b0;
    win_id = '0;
    win_p  = '0;
    for (int i = 0; i < NSRC; i++)
      if (en[i] && pend_eff[i] && depth < DW'(DEPTH) &&
          {1'b1, prio_m[i]} > {depth != 0, top_p} &&
          (!win_ok || prio_m[i] > win_p)) begin
        win_ok = 1'b1;
        win_id = SW'(i);
        win_p  = prio_m[i];
      end
  end

  always_comb begin
    pend_nxt = pend_l | (src_irq & ~src_prev & edge_m);
    if (ack && edge_m[win_id]) pend_nxt[win_id] = 1'b0;
    if (wr_en && sel_ok && addr == A_SET) pend_nxt[sidx] = 1'b1;
    if (wr_en && sel_ok && addr == A_CLR) pend_nxt[sidx] = 1'b0;
  end

  always_comb begin
    case (addr)
      A_SEL:   rdata = {25'b0, sel};
      A_MODE:  rdata = sel_ok ? {25'b0, 1'b0, edge_m[sidx], 2'b00, prio_m[sidx]} : '0;
      A_VEC:   rdata = sel_ok ? vec_m[sidx] : '0;
      A_IVR:   rdata = win_ok ? vec_m[win_id] : spu;
      A_ISR:   rdata = {25'b0, cur_id};
      A_PW0:   rdata = pend_pad[31:0];
      A_PW1:   rdata = pend_pad[63:32];
      A_PW2:   rdata = pend_pad[95:64];
      A_PW3:   rdata = pend_pad[127:96];
      A_MSK:   rdata = {31'b0, sel_ok & en[sidx]};
      A_CST:   rdata = {31'b0, irq_q};
      A_SPU:   rdata = spu;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0; en <= '0; edge_m <= '0; pend_l <= '0; src_prev <= '0;
      spu <= '0; depth <= '0; irq_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        prio_m[i] <= '0;
        vec_m[i]  <= '0;
      end
      for (int d = 0; d < DEPTH; d++) begin
        stk_p[d]  <= '0;
        stk_id[d] <= '0;
      end
    end else begin
      src_prev <= src_irq;
      pend_l   <= pend_nxt;
      irq_q    <= win_ok;
      if (wr_en)
        case (addr)
          A_SEL:  sel <= wdata[SW-1:0];
          A_MODE: if (sel_ok) begin
                    prio_m[sidx] <= wdata[PW-1:0];
                    edge_m[sidx] <= wdata[5];
                  end
          A_VEC:  if (sel_ok) vec_m[sidx] <= wdata;
          A_SPU:  spu <= wdata;
          A_EN:   if (sel_ok) en[sidx] <= 1'b1;
          A_DIS:  if (sel_ok) en[sidx] <= 1'b0;
          default: ;
        endcase
      if (ack) begin
        stk_p[IW'(depth)]  <= win_p;
        stk_id[IW'(depth)] <= win_id;
        depth <= depth + DW'(1);
      end else if (eoi) begin
        depth <= depth - DW'(1);
      end
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH)) else $error("stack overflow"); // R11
  AST_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack) |=> depth == $past(depth) - DW'(1)) else $error("eoi pop"); // R11
  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (depth == $past(depth) + DW'(1)) && top_p == $past(win_p) && cur_id == $past(win_id))
    else $error("ack push"); // R9
  AST_SPURIOUS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_IVR && !win_ok && !wr_en) |=> $stable(depth)) else $error("spurious push"); // R8
  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|(en & pend_eff))) else $error("irq without source"); // R6
  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && edge_m[win_id]) |=> !pend_l[$past(win_id)]) else $error("edge not cleared"); // R10
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int NSRC = 40;
  localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08, A_IVR = 8'h10,
                         A_ISR = 8'h18, A_MSK = 8'h30, A_CST = 8'h34, A_EOI = 8'h38,
                         A_SPU = 8'h3C, A_EN = 8'h40, A_DIS = 8'h44, A_CLR = 8'h48,
                         A_SET = 8'h4C;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NSRC-1:0] src = '0;
  logic irq_out;

  vec_irq_ctrl #(.NSRC(NSRC), .DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_irq(src), .irq_out(irq_out));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [2:0]  m_prio [NSRC];
  logic [31:0] m_vec  [NSRC];
  logic        m_trig [NSRC], m_en [NSRC], m_latch [NSRC], m_src [NSRC];
  logic [2:0]  ms_p  [8];
  int          ms_id [8];
  int          mdep = 0;
  logic [31:0] m_spu = 0;
  logic [31:0] d;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic m_pend(int i);
    return m_latch[i] | (!m_trig[i] & m_src[i]);
  endfunction

  function automatic int m_win();
    int w = -1;
    for (int i = 0; i < NSRC; i++)
      if (m_en[i] && m_pend(i) && mdep < 8 && (mdep == 0 || m_prio[i] > ms_p[mdep-1]) &&
          (w < 0 || m_prio[i] > m_prio[w]))
        w = i;
    return w;
  endfunction

  function automatic logic [31:0] m_word(int k);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++)
      if (32*k + b < NSRC) r[b] = m_pend(32*k + b);
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_irq(input string tag);
    @(negedge clk);
    chk(tag, {31'b0, irq_out}, {31'b0, m_win() >= 0});
  endtask

  task automatic t_cfg(int s, logic trig, logic [2:0] p, logic [31:0] v);
    wr(A_SEL, s);
    wr(A_MODE, {25'b0, 1'b0, trig, 2'b00, p});
    wr(A_VEC, v);
    if (s < NSRC) begin m_trig[s] = trig; m_prio[s] = p; m_vec[s] = v; end
    rd(A_MODE, d); chk("R2 mode readback", d, s < NSRC ? {25'b0, 1'b0, trig, 2'b00, p} : 32'h0);
    rd(A_VEC, d);  chk("R2 vector readback", d, s < NSRC ? v : 32'h0);
  endtask

  task automatic t_en(int s, logic on);
    wr(A_SEL, s);
    wr(on ? A_EN : A_DIS, 0);
    if (s < NSRC) m_en[s] = on;
    rd(A_MSK, d); chk("R3 mask bit", d, {31'b0, s < NSRC ? on : 1'b0});
  endtask

  task automatic t_pend(int s, logic on);
    wr(A_SEL, s);
    wr(on ? A_SET : A_CLR, 0);
    if (s < NSRC) m_latch[s] = on;
  endtask

  task automatic t_src(int i, logic v);
    @(negedge clk); src[i] = v;
    @(negedge clk);
    if (v && !m_src[i] && m_trig[i]) m_latch[i] = 1;
    m_src[i] = v;
  endtask

  task automatic t_words();
    for (int k = 0; k < 4; k++) begin
      rd(8'h20 + 8'(4*k), d);
      chk("R4 pending word", d, m_word(k));
    end
  endtask

  task automatic t_ack();
    int w = m_win();
    rd(A_IVR, d);
    if (w >= 0) begin
      chk("R7 vector of winner", d, m_vec[w]);
      ms_p[mdep] = m_prio[w]; ms_id[mdep] = w; mdep++;
      if (m_trig[w]) m_latch[w] = 0;
    end else chk("R8 spurious vector", d, m_spu);
    rd(A_ISR, d);
    chk("R9 current source", d, mdep > 0 ? ms_id[mdep-1] : 0);
    t_irq("R6 request after ack");
  endtask

  task automatic t_eoi();
    wr(A_EOI, 0);
    if (mdep > 0) mdep--;
  endtask

  initial begin
    #(10 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      m_prio[i] = 0; m_vec[i] = 0; m_trig[i] = 0; m_en[i] = 0; m_latch[i] = 0; m_src[i] = 0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq low", {31'b0, irq_out}, 32'h0);
    rd(A_IVR, d); chk("R1 vector reset", d, 32'h0);
    rd(A_ISR, d); chk("R1 status reset", d, 32'h0);
    rd(8'h20, d); chk("R1 pending reset", d, 32'h0);
    // R8 spurious with programmed value
    wr(A_SPU, 32'hDEAD_BEEF); m_spu = 32'hDEAD_BEEF;
    t_ack();
    // R2 selection and out-of-range select
    t_cfg(3, 0, 5, 32'h300);
    wr(A_SEL, 4); rd(A_MODE, d); chk("R2 other source untouched", d, 32'h0);
    t_cfg(100, 1, 7, 32'h77);
    // R3 enable selected only
    t_en(3, 1);
    wr(A_SEL, 4); rd(A_MSK, d); chk("R3 neighbour disabled", d, 32'h0);
    // R4 set command, word 1 bit 1 = source 33
    t_pend(33, 1);
    rd(8'h24, d); chk("R4 source 33 in word 1", d, 32'h2);
    t_irq("R6 disabled source ignored");
    t_pend(3, 1);
    t_irq("R6 enabled pending raises");
    rd(A_CST, d); chk("R12 core status", d, 32'h1);
    // R7 tie and R9 nesting
    t_cfg(10, 0, 5, 32'h1000); t_en(10, 1); t_pend(10, 1);
    t_cfg(5, 0, 5, 32'h500);   t_en(5, 1);  t_pend(5, 1);
    rd(A_IVR, d); chk("R7 lowest number wins tie", d, 32'h300);
    ms_p[0] = 5; ms_id[0] = 3; mdep = 1;
    rd(A_ISR, d); chk("R9 status after ack", d, 32'd3);
    t_irq("R9 same level blocked");
    t_ack();
    t_cfg(7, 0, 6, 32'h700); t_en(7, 1); t_pend(7, 1);
    t_irq("R9 higher preempts");
    t_ack();
    // R11 full unwind with extra pops
    repeat (8) t_eoi();
    rd(A_ISR, d); chk("R11 stack empty", d, 32'h0);
    t_irq("R11 request after unwind");
    t_pend(3, 0); t_pend(5, 0); t_pend(7, 0); t_pend(10, 0); t_pend(33, 0);
    t_irq("R4 cleared");
    // R5 and R10 edge versus level
    t_cfg(20, 1, 2, 32'h2000); t_en(20, 1);
    t_src(20, 1); t_src(20, 0);
    rd(8'h20, d); chk("R5 edge latched", d, 32'h0010_0000);
    t_ack();
    rd(8'h20, d); chk("R10 edge cleared by ack", d, 32'h0);
    t_eoi();
    t_cfg(21, 0, 1, 32'h2100); t_en(21, 1);
    t_src(21, 1);
    rd(8'h20, d); chk("R5 level follows input", d, 32'h0020_0000);
    t_ack();
    rd(8'h20, d); chk("R10 level stays pending", d, 32'h0020_0000);
    t_eoi();
    t_src(21, 0);
    rd(8'h20, d); chk("R5 level drops", d, 32'h0);
    t_words();
    // random phase
    for (int n = 0; n < 700; n++) begin
      int op = $urandom % 8;
      int s = $urandom % (NSRC + 4);
      int si = $urandom % NSRC;
      case (op)
        0: t_cfg(s, 1'($urandom), 3'($urandom), $urandom);
        1: t_en(s, 1'($urandom));
        2: t_src(si, !m_src[si]);
        3: t_pend(s, ($urandom % 3) != 0);
        4, 5: t_ack();
        6: t_eoi();
        default: begin
          t_words();
          rd(A_CST, d); chk("R12 core status", d, {31'b0, m_win() >= 0});
        end
      endcase
      t_irq("R6 request level");
    end
    repeat (8) t_eoi();
    rd(A_ISR, d); chk("R11 final unwind", d, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule